// File: doc/BRIEF.md
# Sequential Signed/Unsigned Integer Divider

This block divides a double-width dividend by a single-width divisor over several clock cycles and returns a packed quotient and remainder. It handles two operand sizes (8-bit and 16-bit by default), and both unsigned and two's-complement signed numbers. A start pulse begins a divide, and a one-cycle done pulse marks completion. A divide-error flag goes high alongside done when the quotient cannot be represented. On an error the surrounding core is expected to raise its own divide exception.

The datapath works on magnitudes. Restoring division produces one quotient bit per cycle, and signs are fixed in a final cycle. The quotient truncates toward zero and the remainder takes the sign of the dividend, so dividend = divisor × quotient + remainder always holds. A zero divisor, or a quotient magnitude that provably needs more than one operand width, is rejected in the first cycle without iterating. A mode input selects whether a quotient equal to the most-negative signed value is legal or treated as an error.

Top module: `seq_div`

## Requirements
- R1: While `rst` is high, and after any clock edge on which it is high (including during a divide), `done`, `div_err` and `result` are all zero.
- R2: `size_wide`=1 selects 16-bit operands: `dividend[31:0]` by `divisor[15:0]`, with the remainder in `result[31:16]` and the quotient in `result[15:0]`. `size_wide`=0 selects 8-bit operands: `dividend[15:0]` by `divisor[7:0]`, with the upper input bits ignored, the remainder in `result[15:8]`, the quotient in `result[7:0]` and `result[31:16]`=0. `is_signed`=1 treats operands and results as two's complement; `is_signed`=0 treats them as unsigned.
- R3: A signed quotient truncates toward zero and the remainder has the sign of the dividend. For example, 23/5 = 4 r 3, 23/−5 = −4 r 3, −23/5 = −4 r −3 and −23/−5 = 4 r −3.
- R4: An unsigned quotient above the operand maximum raises `div_err`. In 8-bit mode, 2550/10 gives 0xFF r 0 and 2555/10 gives 0xFF r 5, while 2560/10 is an error.
- R5: A signed quotient above the largest positive value raises `div_err`. For example, 1270/10 gives 0x7F, while 1280/10 and (16-bit) 32768/1 are errors.
- R6: A negative quotient equal to the most-negative value (0x80 or 0x8000) raises `div_err` when `allow_min_quot`=0 and is a legal result when `allow_min_quot`=1. For example, 1285/−10 gives 0x80 r 5. Negative quotients of smaller magnitude are legal in both modes: 1270/−10 gives 0x81 r 0 and 1275/−10 gives 0x81 r 5.
- R7: If the divisor is zero, or if the upper half of the dividend magnitude is at least the divisor magnitude, `done` and `div_err` are high in the cycle right after the edge that samples `start`.
- R8: Any other divide sampled at edge k raises `done` in the cycle after edge k+n+1, where n is the operand width (8 or 16).
- R9: `div_err` is high only together with `done`, and on an error `result` keeps its previous value.
- R10: A `start` that arrives while a divide is in progress is ignored. It changes neither the running result nor the completion time, and it causes no extra `done`.
- R11: `done` is high for exactly one cycle per accepted divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a divide (sampled only when idle) |
| size_wide | input | 1 | 1: 16-bit operands, 0: 8-bit operands |
| is_signed | input | 1 | 1: two's-complement divide, 0: unsigned |
| allow_min_quot | input | 1 | 1: most-negative quotient is legal |
| dividend | input | 32 | Double-width dividend |
| divisor | input | 16 | Divisor |
| result | output | 32 | Packed remainder (high half) and quotient (low half) |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error, valid with done |

## Verification
Results arrive at one of three latencies: one cycle for the early rejections, ten cycles for an 8-bit divide and eighteen cycles for a 16-bit divide, counted in falling edges after the edge that samples `start`. The bench drives `start` on a falling edge and counts falling edges until `done` is seen. It then compares the measured count against the latency expected for that vector, so a divide that finishes one cycle early or late is caught. The bench samples `result` and `div_err` in that same cycle, and checks on the following falling edge that `done` has dropped.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } div_state_e;

  // Operation context captured when a divide is accepted
  typedef struct packed {
    logic wide;
    logic sgn;
    logic allow_min;
    logic dvd_neg;
    logic dvs_neg;
  } div_ctx_t;

endpackage

// File: rtl/seqdiv_prep.sv
// Operand conditioning: sign extraction, magnitudes, half split, early reject
module seqdiv_prep #(
  parameter int OPW = 16,
  parameter int OPN = 8
) (
  input  logic             size_wide,
  input  logic             is_signed,
  input  logic [2*OPW-1:0] dividend,
  input  logic [OPW-1:0]   divisor,
  output logic [OPW-1:0]   hi_mag,
  output logic [OPW-1:0]   lo_mag,
  output logic [OPW-1:0]   dvs_mag,
  output logic             dvd_neg,
  output logic             dvs_neg,
  output logic             early_err
);
  localparam int DVW = 2 * OPW;
  localparam int NDW = 2 * OPN;
  localparam int PADW = OPW - OPN;

  logic [DVW-1:0] dvd_ext, dvd_mag;
  logic [OPW-1:0] dvs_ext;

  always_comb begin
    dvd_neg = is_signed & (size_wide ? dividend[DVW-1] : dividend[NDW-1]);
    dvs_neg = is_signed & (size_wide ? divisor[OPW-1] : divisor[OPN-1]);
    dvd_ext = size_wide ? dividend : {{(DVW-NDW){dvd_neg}}, dividend[NDW-1:0]};
    dvs_ext = size_wide ? divisor  : {{PADW{dvs_neg}}, divisor[OPN-1:0]};
    dvd_mag = dvd_neg ? (~dvd_ext + 1'b1) : dvd_ext;
    dvs_mag = dvs_neg ? (~dvs_ext + 1'b1) : dvs_ext;
    // narrow mode: high half right-aligned, low half left-aligned so that
    // the quotient bits land in the low part after OPN shifts
    hi_mag  = size_wide ? dvd_mag[DVW-1:OPW] : {{PADW{1'b0}}, dvd_mag[NDW-1:OPN]};
    lo_mag  = size_wide ? dvd_mag[OPW-1:0]   : {dvd_mag[OPN-1:0], {PADW{1'b0}}};
    // quotient magnitude would need more than n bits (covers zero divisor)
    early_err = (hi_mag >= dvs_mag);
  end

endmodule

// File: rtl/seqdiv_step.sv
// One restoring-division step: shift in one dividend bit, trial subtract
module seqdiv_step #(
  parameter int OPW = 16
) (
  input  logic [OPW-1:0] rem_in,
  input  logic           shift_in,
  input  logic [OPW-1:0] dvs,
  output logic [OPW-1:0] rem_out,
  output logic           qbit
);
  logic [OPW:0] trial;

  always_comb begin
    trial   = {rem_in, shift_in};
    qbit    = (trial >= {1'b0, dvs});
    rem_out = OPW'(qbit ? (trial - {1'b0, dvs}) : trial);
  end

endmodule

// File: rtl/seqdiv_fix.sv
// Sign correction, signed range check and result packing
module seqdiv_fix
  import seqdiv_pkg::*;
#(
  parameter int OPW = 16,
  parameter int OPN = 8
) (
  input  div_ctx_t         ctx,
  input  logic [OPW-1:0]   quo_raw,
  input  logic [OPW-1:0]   rem_raw,
  output logic [2*OPW-1:0] packed_res,
  output logic             range_err
);
  localparam int PADW = OPW - OPN;
  localparam logic [OPW-1:0] MIN_WIDE   = OPW'(1) << (OPW - 1);
  localparam logic [OPW-1:0] MIN_NARROW = OPW'(1) << (OPN - 1);

  logic [OPW-1:0] qmag, min_mag, qval, rval;
  logic           q_neg;

  always_comb begin
    qmag    = ctx.wide ? quo_raw : {{PADW{1'b0}}, quo_raw[OPN-1:0]};
    min_mag = ctx.wide ? MIN_WIDE : MIN_NARROW;
    q_neg   = ctx.dvd_neg ^ ctx.dvs_neg;
    if (!ctx.sgn)
      range_err = 1'b0;
    else if (q_neg)
      range_err = (qmag > min_mag) || (!ctx.allow_min && (qmag == min_mag));
    else
      range_err = (qmag >= min_mag);
    qval = q_neg       ? (~qmag + 1'b1)    : qmag;
    rval = ctx.dvd_neg ? (~rem_raw + 1'b1) : rem_raw;
    packed_res = ctx.wide ? {rval, qval}
                          : {{(2*PADW){1'b0}}, rval[OPN-1:0], qval[OPN-1:0]};
  end

endmodule

// File: rtl/seq_div.sv
module seq_div
  import seqdiv_pkg::*;
#(
  parameter int OPW = 16,
  parameter int OPN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             size_wide,
  input  logic             is_signed,
  input  logic             allow_min_quot,
  input  logic [2*OPW-1:0] dividend,
  input  logic [OPW-1:0]   divisor,
  output logic [2*OPW-1:0] result,
  output logic             done,
  output logic             div_err
);
  localparam int CW = $clog2(OPW);
  localparam logic [CW-1:0] LAST_WIDE   = CW'(OPW - 1);
  localparam logic [CW-1:0] LAST_NARROW = CW'(OPN - 1);

  div_state_e     state;
  logic [CW-1:0]  cnt;
  logic [OPW-1:0] rem_q, quo_q, dvs_q;
  div_ctx_t       ctx_q, ctx_in;
  logic           busy;

  logic [OPW-1:0]   hi_mag, lo_mag, dvs_mag, step_rem;
  logic             dvd_neg, dvs_neg, early_err, step_q, range_err;
  logic [2*OPW-1:0] fixed_res;

  assign busy = (state != ST_IDLE);

  seqdiv_prep #(.OPW(OPW), .OPN(OPN)) u_prep (
    .size_wide (size_wide),
    .is_signed (is_signed),
    .dividend  (dividend),
    .divisor   (divisor),
    .hi_mag    (hi_mag),
    .lo_mag    (lo_mag),
    .dvs_mag   (dvs_mag),
    .dvd_neg   (dvd_neg),
    .dvs_neg   (dvs_neg),
    .early_err (early_err)
  );

  seqdiv_step #(.OPW(OPW)) u_step (
    .rem_in   (rem_q),
    .shift_in (quo_q[OPW-1]),
    .dvs      (dvs_q),
    .rem_out  (step_rem),
    .qbit     (step_q)
  );

  seqdiv_fix #(.OPW(OPW), .OPN(OPN)) u_fix (
    .ctx        (ctx_q),
    .quo_raw    (quo_q),
    .rem_raw    (rem_q),
    .packed_res (fixed_res),
    .range_err  (range_err)
  );

  always_comb begin
    ctx_in.wide      = size_wide;
    ctx_in.sgn       = is_signed;
    ctx_in.allow_min = allow_min_quot;
    ctx_in.dvd_neg   = dvd_neg;
    ctx_in.dvs_neg   = dvs_neg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      ctx_q   <= '0;
      result  <= '0;
      done    <= 1'b0;
      div_err <= 1'b0;
    end else begin
      done    <= 1'b0;
      div_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            ctx_q <= ctx_in;
            if (early_err) begin
              done    <= 1'b1;
              div_err <= 1'b1;
            end else begin
              state <= ST_RUN;
              cnt   <= size_wide ? LAST_WIDE : LAST_NARROW;
              rem_q <= hi_mag;
              quo_q <= lo_mag;
              dvs_q <= dvs_mag;
            end
          end
        end
        ST_RUN: begin
          rem_q <= step_rem;
          quo_q <= {quo_q[OPW-2:0], step_q};
          if (cnt == '0) state <= ST_FIN;
          else           cnt   <= cnt - 1'b1;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (range_err) div_err <= 1'b1;
          else           result  <= fixed_res;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seqdiv_checker.sv
module seqdiv_checker #(
  parameter int OPW = 16,
  parameter int OPN = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             size_wide,
  input logic [OPW-1:0]   divisor,
  input logic             busy,
  input logic             done,
  input logic             div_err,
  input logic [2*OPW-1:0] result
);
  logic zero_dvs;
  assign zero_dvs = size_wide ? (divisor == '0) : (divisor[OPN-1:0] == '0);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    div_err |-> done);

  assert_err_keeps_result_R9: assert property (@(posedge clk) disable iff (rst)
    div_err |-> $stable(result));

  assert_zero_divisor_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && zero_dvs) |=> (done && div_err));

  assert_no_spurious_done_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !done);

  assert_run_completes_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

endmodule

bind seq_div seqdiv_checker #(.OPW(OPW), .OPN(OPN)) u_seqdiv_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .size_wide (size_wide),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .div_err   (div_err),
  .result    (result)
);

// File: tb/test_seq_div.sv
module test_seq_div;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        size_wide = 1'b0;
  logic        is_signed = 1'b0;
  logic        allow_min_quot = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic [31:0] result;
  logic        done;
  logic        div_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_div i_seq_div (
    .clk(clk), .rst(rst), .start(start), .size_wide(size_wide),
    .is_signed(is_signed), .allow_min_quot(allow_min_quot),
    .dividend(dividend), .divisor(divisor),
    .result(result), .done(done), .div_err(div_err)
  );

  // {size_wide, is_signed, allow_min, dividend, divisor, exp_err, exp_result, exp_latency}
  // latency counted in falling edges after the start edge: 1 early, 10 narrow, 18 wide
  localparam logic [91:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,32'h000009F6,16'h000A,1'b0,32'h000000FF,8'd10}, // R4 2550/10
    {1'b0,1'b0,1'b0,32'h000009FB,16'h000A,1'b0,32'h000005FF,8'd10}, // R4 2555/10
    {1'b0,1'b0,1'b0,32'h00000A00,16'h000A,1'b1,32'h000005FF,8'd1 }, // R4 2560/10 error
    {1'b0,1'b1,1'b0,32'h00000017,16'h0005,1'b0,32'h00000304,8'd10}, // R3 23/5
    {1'b0,1'b1,1'b0,32'h00000017,16'h00FB,1'b0,32'h000003FC,8'd10}, // R3 23/-5
    {1'b0,1'b1,1'b0,32'h0000FFE9,16'h0005,1'b0,32'h0000FDFC,8'd10}, // R3 -23/5
    {1'b0,1'b1,1'b0,32'h0000FFE9,16'h00FB,1'b0,32'h0000FD04,8'd10}, // R3 -23/-5
    {1'b0,1'b1,1'b0,32'h000004F6,16'h000A,1'b0,32'h0000007F,8'd10}, // R5 1270/10
    {1'b0,1'b1,1'b0,32'h00000500,16'h000A,1'b1,32'h0000007F,8'd10}, // R5 1280/10 error
    {1'b0,1'b1,1'b0,32'h000004F6,16'h00F6,1'b0,32'h00000081,8'd10}, // R6 1270/-10 legacy
    {1'b0,1'b1,1'b1,32'h000004FB,16'h00F6,1'b0,32'h00000581,8'd10}, // R6 1275/-10
    {1'b0,1'b1,1'b1,32'h00000505,16'h00F6,1'b0,32'h00000580,8'd10}, // R6 1285/-10 allowed
    {1'b0,1'b1,1'b0,32'h00000505,16'h00F6,1'b1,32'h00000580,8'd10}, // R6 1285/-10 legacy error
    {1'b1,1'b0,1'b0,32'h00012345,16'h0100,1'b0,32'h00450123,8'd18}, // R2 wide unsigned
    {1'b1,1'b1,1'b0,32'hFFFE7960,16'h0007,1'b0,32'hFFFBC833,8'd18}, // R3 -100000/7
    {1'b1,1'b0,1'b0,32'h00001234,16'h0000,1'b1,32'hFFFBC833,8'd1 }, // R7 zero divisor
    {1'b1,1'b1,1'b1,32'hFFFF8000,16'h0001,1'b0,32'h00008000,8'd18}, // R6 -32768/1 allowed
    {1'b1,1'b1,1'b0,32'hFFFF8000,16'h0001,1'b1,32'h00008000,8'd18}, // R6 -32768/1 legacy error
    {1'b1,1'b1,1'b1,32'h00008000,16'h0001,1'b1,32'h00008000,8'd18}, // R5 32768/1 error
    {1'b0,1'b0,1'b0,32'hABCD0064,16'hFF07,1'b0,32'h0000020E,8'd10}  // R2 upper bits ignored
  };

  function automatic string req_of(int i);
    case (i)
      0, 1, 2:            return "R4";
      3, 4, 5, 6, 14:     return "R3";
      7, 8, 18:           return "R5";
      9, 10, 11, 12, 16, 17: return "R6";
      15:                 return "R7";
      default:            return "R2";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run_op(input logic sz, input logic sg, input logic al,
                        input logic [31:0] dd, input logic [15:0] ds,
                        output int lat);
    @(negedge clk);
    size_wide = sz; is_signed = sg; allow_min_quot = al;
    dividend = dd; divisor = ds; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R8 watchdog actual hang expected completion");
    summary();
  end

  initial begin
    int lat;
    int extra;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "reset result", result, 32'h0);
    check("R1", "reset done", {31'b0, done}, 32'h0);
    check("R1", "reset div_err", {31'b0, div_err}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [91:0] v;
      v = VEC[i];
      run_op(v[91], v[90], v[89], v[88:57], v[56:41], lat);
      check("R8", $sformatf("vector %0d latency", i), 32'(lat), 32'(v[7:0]));
      check(v[40] ? "R9" : req_of(i), $sformatf("vector %0d result", i), result, v[39:8]);
      check(req_of(i), $sformatf("vector %0d div_err", i), {31'b0, div_err}, {31'b0, v[40]});
      @(negedge clk);
      check("R11", $sformatf("vector %0d done drops", i), {31'b0, done}, 32'h0);
    end

    // R10: start while busy is ignored (second start carries a zero divisor)
    @(negedge clk);
    size_wide = 1'b1; is_signed = 1'b0; allow_min_quot = 1'b0;
    dividend = 32'h000003E8; divisor = 16'h0003; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    @(negedge clk);
    lat++;
    divisor = 16'h0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat++;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R10", "busy start latency", 32'(lat), 32'd18);
    check("R10", "busy start result", result, 32'h0001014D);
    check("R10", "busy start div_err", {31'b0, div_err}, 32'h0);
    extra = 0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R10", "no extra done", 32'(extra), 32'h0);

    // R1: reset in the middle of a divide
    @(negedge clk);
    dividend = 32'h00012345; divisor = 16'h0100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "mid-run reset result", result, 32'h0);
    check("R1", "mid-run reset done", {31'b0, done}, 32'h0);
    rst = 1'b0;
    extra = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R1", "no done after reset", 32'(extra), 32'h0);

    // R2: narrow divide works after the reset, 100/7
    run_op(1'b0, 1'b0, 1'b0, 32'h00000064, 16'h0007, lat);
    check("R8", "post-reset latency", 32'(lat), 32'd10);
    check("R2", "post-reset result", result, 32'h0000020E);
    summary();
  end

endmodule